// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This block derives the bit clock of a CAN node from the local system clock. A programmable prescaler divides the system clock into time quanta (TQ). Each bit is laid out as a fixed one-quantum sync slot, then a propagation slot, a first phase slot and a second phase slot. The programmable lengths of these slots set the bit rate and the place where the receive line is sampled. Nodes with different oscillators can therefore share one bus bit rate by picking suitable prescaler and slot values.

The unit follows the transmitter on the bus. It watches the receive line for recessive-to-dominant (1-to-0) transitions. A late edge stretches the first phase slot. An early edge cuts the second phase slot short. Each correction is capped by a programmable jump width. While the bus is idle, an edge starts a new bit at once (hard synchronization). The unit gives a one-clock sample strobe with the sampled bit, and a one-clock transmit strobe that marks where the next bit should be driven. Frame decoding, stuffing and error handling sit in neighbouring logic. The slot lengths are static configuration inputs. `rx_in` must be synchronous to `clk`.

Top module: `can_bit_timer`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `sample_stb` and `tx_stb` are 0 and `sample_bit` is 1.
- R2: One TQ lasts 2*(`brp`+1) clock cycles. With no edges on `rx_in`, the rising edges of `tx_stb` are (1+P+A+B) TQ apart. Here P=`prop_m1`+1, A=`ph1_m1`+1 and B=`ph2_m1`+1; each field holds its slot length minus one, so each slot is 1 to 8 TQ.
- R3: With no resynchronization, `sample_stb` rises (1+P+A) TQ after `tx_stb`, at the end of the first phase slot. `sample_bit` then carries the level of `rx_in` at that quantum boundary.
- R4: `sample_stb` and `tx_stb` are each exactly one clock cycle wide, and they are never high together. `tx_stb` marks the start of each sync slot that the nominal bit sequence reaches.
- R5: Number the quanta of a bit from 0 at the sync slot. A falling edge of `rx_in` in quantum q, where q is in the propagation or first phase slot, lengthens the first phase slot by min(q, J) TQ. J=`sjw_m1`+1, from 1 to 4. This delays `sample_stb` and the next `tx_stb` by the same amount.
- R6: A falling edge in the second phase slot, with e quanta of that slot still left after the edge's quantum, shortens the slot. If e=0 nothing changes. If e<=J the bit ends after the current quantum. Otherwise the slot is shortened by J TQ.
- R7: At most one resynchronization happens per bit; later edges in the same bit are ignored. An edge inside the sync slot causes no correction.
- R8: While `bus_idle` is 1, a falling edge makes its own quantum the sync slot of a new bit. `sample_stb` then follows (P+A) TQ later, and `tx_stb` (P+A+B) TQ later. No `tx_stb` is issued for that sync slot, and no resynchronization follows in that bit.
- R9: Falling edges seen while `tx_dom` is 1 do not change the timing. Rising edges never change the timing.
- R10: `sample_bit` changes only in cycles where `sample_stb` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| brp | input | 6 | Prescaler value; TQ = 2*(brp+1) clocks |
| prop_m1 | input | 3 | Propagation slot length minus one, in TQ |
| ph1_m1 | input | 3 | First phase slot length minus one, in TQ |
| ph2_m1 | input | 3 | Second phase slot length minus one, in TQ |
| sjw_m1 | input | 2 | Jump width minus one, in TQ |
| rx_in | input | 1 | Receive line, 1 = recessive, synchronous to clk |
| tx_dom | input | 1 | High while this node itself drives dominant |
| bus_idle | input | 1 | High while the bus is idle; enables hard sync |
| sample_stb | output | 1 | One-clock strobe at the sample point |
| sample_bit | output | 1 | Receive level captured at the last sample point |
| tx_stb | output | 1 | One-clock strobe at the start of a bit |

## Verification
A wrong quantum counter or slot-length decode shows up at the ports within one bit. The spacing of `tx_stb` pulses, or the offset from `tx_stb` to `sample_stb`, moves by a whole multiple of TQ. A faulty correction path, such as a wrong cap, a wrong sign, or a second correction in one bit, changes the offset or period of the very bit that holds the stimulus edge. Each such test therefore drops the edge into a chosen quantum and measures that one bit. A stale phase-length register would carry its error into the following bit, where the nominal period check catches it.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;
endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BRP_W-1:0] brp,
  output logic             tq_tick
);
  localparam int CW = BRP_W + 1;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  // 2*(brp+1) clocks per quantum: the last count is 2*brp+1
  assign limit   = {brp, 1'b1};
  assign tq_tick = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (tq_tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cbt_edge_det.sv
module cbt_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic tq_tick,
  input  logic rx_in,
  input  logic tx_dom,
  output logic fall
);
  logic rx_prev;

  // only recessive-to-dominant transitions while not driving dominant
  assign fall = tq_tick & rx_prev & ~rx_in & ~tx_dom;

  always_ff @(posedge clk) begin
    if (rst) rx_prev <= 1'b1;
    else if (tq_tick) rx_prev <= rx_in;
  end
endmodule

// File: rtl/cbt_seq.sv
module cbt_seq
  import can_bt_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tq_tick,
  input  logic             fall,
  input  logic             rx_in,
  input  logic             bus_idle,
  input  logic [SEG_W-1:0] prop_m1,
  input  logic [SEG_W-1:0] ph1_m1,
  input  logic [SEG_W-1:0] ph2_m1,
  input  logic [SJW_W-1:0] sjw_m1,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             tx_stb
);
  localparam int LW = SEG_W + 2;

  seg_e          seg;
  logic [LW-1:0] cnt, qpos, ph1_eff, ph2_eff;
  logic          done;
  logic [LW-1:0] ph1_nom, ph2_nom, prop_last, sjw_len, ext, early_err;
  logic          resync, ph1_end, ph2_end;

  always_comb begin
    ph1_nom   = LW'(ph1_m1) + 1'b1;
    ph2_nom   = LW'(ph2_m1) + 1'b1;
    prop_last = LW'(prop_m1);
    sjw_len   = LW'(sjw_m1) + 1'b1;
    ext       = (qpos < sjw_len) ? qpos : sjw_len;
    early_err = ph2_eff - cnt - 1'b1;
    resync    = fall && !done && (seg != SEG_SYNC);
    ph1_end   = !resync && (cnt == ph1_eff - 1'b1);
    ph2_end   = (cnt == ph2_eff - 1'b1) ||
                (resync && (early_err != '0) && (early_err <= sjw_len));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg        <= SEG_SYNC;
      cnt        <= '0;
      qpos       <= '0;
      ph1_eff    <= ph1_nom;
      ph2_eff    <= ph2_nom;
      done       <= 1'b0;
      sample_stb <= 1'b0;
      sample_bit <= 1'b1;
      tx_stb     <= 1'b0;
    end else begin
      sample_stb <= 1'b0;
      tx_stb     <= 1'b0;
      if (tq_tick) begin
        if (fall && bus_idle) begin
          // hard sync: this quantum becomes the sync slot
          seg     <= SEG_PROP;
          cnt     <= '0;
          qpos    <= LW'(1);
          ph1_eff <= ph1_nom;
          ph2_eff <= ph2_nom;
          done    <= 1'b1;
        end else begin
          qpos <= qpos + 1'b1;
          unique case (seg)
            SEG_SYNC: begin
              seg <= SEG_PROP;
              cnt <= '0;
            end
            SEG_PROP: begin
              if (resync) begin
                ph1_eff <= ph1_nom + ext;
                done    <= 1'b1;
              end
              if (cnt == prop_last) begin
                seg <= SEG_PH1;
                cnt <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            SEG_PH1: begin
              if (resync) begin
                ph1_eff <= ph1_nom + ext;
                done    <= 1'b1;
              end
              if (ph1_end) begin
                seg        <= SEG_PH2;
                cnt        <= '0;
                sample_stb <= 1'b1;
                sample_bit <= rx_in;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            SEG_PH2: begin
              if (ph2_end) begin
                seg     <= SEG_SYNC;
                cnt     <= '0;
                qpos    <= '0;
                ph1_eff <= ph1_nom;
                ph2_eff <= ph2_nom;
                done    <= 1'b0;
                tx_stb  <= 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
                if (resync && (early_err != '0)) begin
                  ph2_eff <= ph2_eff - sjw_len;
                  done    <= 1'b1;
                end
              end
            end
            default: seg <= SEG_SYNC;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = 6,
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BRP_W-1:0] brp,
  input  logic [SEG_W-1:0] prop_m1,
  input  logic [SEG_W-1:0] ph1_m1,
  input  logic [SEG_W-1:0] ph2_m1,
  input  logic [SJW_W-1:0] sjw_m1,
  input  logic             rx_in,
  input  logic             tx_dom,
  input  logic             bus_idle,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             tx_stb
);
  logic tq_tick, fall;

  cbt_prescaler #(.BRP_W(BRP_W)) u_pre (
    .clk(clk), .rst(rst), .brp(brp), .tq_tick(tq_tick)
  );

  cbt_edge_det u_edge (
    .clk(clk), .rst(rst), .tq_tick(tq_tick), .rx_in(rx_in),
    .tx_dom(tx_dom), .fall(fall)
  );

  cbt_seq #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_seq (
    .clk(clk), .rst(rst), .tq_tick(tq_tick), .fall(fall), .rx_in(rx_in),
    .bus_idle(bus_idle), .prop_m1(prop_m1), .ph1_m1(ph1_m1),
    .ph2_m1(ph2_m1), .sjw_m1(sjw_m1), .sample_stb(sample_stb),
    .sample_bit(sample_bit), .tx_stb(tx_stb)
  );
endmodule

// File: rtl/can_bt_chk.sv
module can_bt_chk (
  input logic clk,
  input logic rst,
  input logic sample_stb,
  input logic sample_bit,
  input logic tx_stb
);
  // R4: strobes never coincide
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb && tx_stb));
  // R4: sample strobe is one clock wide
  a_r4_smp_pulse: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb);
  // R4: transmit strobe is one clock wide
  a_r4_tx_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_stb |=> !tx_stb);
  // R10: sampled bit only moves with its strobe
  a_r10_bit_hold: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |-> $stable(sample_bit));
endmodule

bind can_bit_timer can_bt_chk u_chk (
  .clk(clk), .rst(rst), .sample_stb(sample_stb),
  .sample_bit(sample_bit), .tx_stb(tx_stb)
);

// File: tb/tb_can_bit_timer.sv
module tb_can_bit_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] brp = '0;
  logic [2:0] prop_m1 = '0, ph1_m1 = '0, ph2_m1 = '0;
  logic [1:0] sjw_m1 = '0;
  logic       rx_in = 1'b1, tx_dom = 1'b0, bus_idle = 1'b0;
  logic       sample_stb, sample_bit, tx_stb;
  int         checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  can_bit_timer dut (
    .clk(clk), .rst(rst), .brp(brp), .prop_m1(prop_m1), .ph1_m1(ph1_m1),
    .ph2_m1(ph2_m1), .sjw_m1(sjw_m1), .rx_in(rx_in), .tx_dom(tx_dom),
    .bus_idle(bus_idle), .sample_stb(sample_stb), .sample_bit(sample_bit),
    .tx_stb(tx_stb)
  );

  // brp, prop, ph1, ph2 (real lengths), period, sample offset (clocks)
  localparam int VEC [4][6] = '{
    '{0, 1, 1, 1,   8,   6},
    '{1, 2, 3, 2,  32,  24},
    '{3, 8, 8, 8, 200, 136},
    '{2, 4, 2, 5,  72,  42}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int b, input int p, input int a1, input int a2, input int j);
    brp = 6'(b); prop_m1 = 3'(p - 1); ph1_m1 = 3'(a1 - 1);
    ph2_m1 = 3'(a2 - 1); sjw_m1 = 2'(j - 1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 sample_stb in reset", int'(sample_stb), 0);
    chk("R1 tx_stb in reset", int'(tx_stb), 0);
    chk("R1 sample_bit in reset", int'(sample_bit), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 strobes after reset", int'(sample_stb | tx_stb), 0);
  endtask

  // wait for tx_stb, then edges: fall at quantum d1, rise at quantum r1,
  // fall at quantum d2 (each mid-quantum, -1 = unused); measure one bit
  task automatic run_bit(input int d1, input int r1, input int d2,
                         output int off, output int per, output int bv);
    int tq;
    tq = 2 * (int'(brp) + 1);
    for (int w = 0; w < 5000 && !tx_stb; w++) @(negedge clk);
    off = -1; per = -1; bv = -1;
    for (int k = 1; k <= 5000; k++) begin
      @(negedge clk);
      if (d1 >= 0 && k == d1 * tq + tq / 2) rx_in = 1'b0;
      if (r1 >= 0 && k == r1 * tq + tq / 2) rx_in = 1'b1;
      if (d2 >= 0 && k == d2 * tq + tq / 2) rx_in = 1'b0;
      if (sample_stb && off < 0) begin off = k; bv = int'(sample_bit); end
      if (tx_stb) begin per = k; break; end
    end
    rx_in = 1'b1;
  endtask

  initial begin
    int off, per, bv;
    do_reset();
    // vector table: nominal timing, no edges (R2, R3)
    foreach (VEC[i]) begin
      cfg(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 1);
      do_reset();
      run_bit(-1, -1, -1, off, per, bv);
      chk("R2 nominal period", per, VEC[i][4]);
      chk("R3 sample offset", off, VEC[i][5]);
      chk("R3 sample_bit recessive", bv, 1);
    end

    // tq = 8 clocks, bit = 1+2+3+3 = 9 TQ
    cfg(3, 2, 3, 3, 2); do_reset();
    run_bit(2, -1, -1, off, per, bv);
    chk("R5 late edge q2 sjw2 offset", off, 64);
    chk("R5 late edge q2 sjw2 period", per, 88);
    chk("R3 sample_bit dominant", bv, 0);

    cfg(3, 2, 3, 3, 1); do_reset();
    run_bit(2, -1, -1, off, per, bv);
    chk("R5 late edge capped by sjw1 offset", off, 56);
    chk("R5 late edge capped period", per, 80);

    cfg(3, 2, 3, 3, 4); do_reset();
    run_bit(4, -1, -1, off, per, bv);
    chk("R5 late edge q4 in ph1 sjw4 offset", off, 80);

    run_bit(1, 2, 3, off, per, bv);
    chk("R7 second edge ignored offset", off, 56);
    chk("R7 second edge ignored period", per, 80);

    run_bit(0, -1, -1, off, per, bv);
    chk("R7 edge in sync slot offset", off, 48);

    cfg(3, 2, 3, 3, 1); do_reset();
    run_bit(6, -1, -1, off, per, bv);
    chk("R6 early edge sjw1 offset", off, 48);
    chk("R6 early edge shortened by sjw", per, 64);

    cfg(3, 2, 3, 3, 2); do_reset();
    run_bit(6, -1, -1, off, per, bv);
    chk("R6 early edge e<=sjw period", per, 56);
    run_bit(8, -1, -1, off, per, bv);
    chk("R6 early edge e=0 period", per, 72);

    tx_dom = 1'b1;
    run_bit(2, -1, -1, off, per, bv);
    tx_dom = 1'b0;
    chk("R9 edge during tx_dom offset", off, 48);
    chk("R9 edge during tx_dom period", per, 72);

    run_bit(-1, 3, -1, off, per, bv);
    chk("R9 rising edge ignored offset", off, 48);

    cfg(3, 2, 3, 3, 1); do_reset();
    bus_idle = 1'b1;
    run_bit(4, -1, -1, off, per, bv);
    bus_idle = 1'b0;
    chk("R8 hard sync sample offset", off, 80);
    chk("R8 hard sync period", per, 104);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule